// File: doc/BRIEF.md
# Morphable-code refresh mode sequencer

This block decides when memory may drop to a slow self-refresh and when lines may move between a weak and a strong error code. When the system asks to go idle, the block first upgrades every line that could still hold the weak code back to the strong code. It does this by walking a small bitmap with one bit per memory region and issuing one line request per line through a request/acknowledge port. Only after that walk ends does it enable a refresh divider, which forwards one incoming refresh pulse in sixteen. On wake it returns to full-rate refresh at once.

In active mode the block measures memory activity as misses per fixed window of cycles. It allows on-demand downgrades to the weak code only while the last window's miss count is above a programmable threshold. A downgrade write reported back to the block marks its region for the next idle-entry walk.

A wake during the walk stops it at the next line boundary. Regions that were not completed keep their marks. The codecs, the DRAM and the read/re-encode/write work behind each line request are outside the block.

Top module: `mecc_mode_ctrl`

## Requirements
- R1: After reset `slow_ref_o`, `ln_req_o`, `dg_en_o` and `sweep_busy_o` are all 0.
- R2: A pulse on `dg_wr_i` marks region `dg_rgn_i`. On idle entry the walk visits only marked regions, in ascending region order. Within each region it visits every line in ascending line order, presenting `ln_addr_o = {region, line}` (region in the upper bits).
- R3: A region's mark is cleared when the acknowledge for its last line arrives, so a later idle entry with no new downgrade writes issues no line requests.
- R4: Once raised, `ln_req_o` stays high with `ln_addr_o` unchanged until a cycle with `ln_ack_i` high.
- R5: If `idle_i` falls during the walk, an outstanding line request is held until acknowledged. The block then returns to active (`sweep_busy_o` = 0, `slow_ref_o` = 0). Marks of unfinished regions are kept, and the next walk revisits such a region from line 0.
- R6: `slow_ref_o` rises only after the walk has ended, and no line request is issued while it is high.
- R7: While `slow_ref_o` is high, `ref_pulse_o` fires on the 16th, 32nd, … `ref_pulse_i` pulse. The pulse count restarts from zero on every idle entry.
- R8: While `slow_ref_o` is low, every `ref_pulse_i` pulse appears on `ref_pulse_o` in the same cycle.
- R9: Misses on `miss_i` are counted over consecutive 1024-cycle windows starting at reset release. At the end of each window the downgrade permit is set to (miss count > `thresh_i`, unsigned) and holds that value for the whole next window. It is 0 until the first window ends.
- R10: `dg_en_o` is 0 whenever the block is walking or in slow refresh, whatever the permit.
- R11: When `idle_i` is low in slow refresh, `slow_ref_o` is 0 from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | 1 requests idle mode, 0 requests active mode |
| miss_i | input | 1 | One memory miss this cycle |
| thresh_i | input | $clog2(WINDOW+1) | Miss-count threshold per window |
| dg_wr_i | input | 1 | A downgrade write landed this cycle |
| dg_rgn_i | input | $clog2(N_RGN) | Region of that downgrade write |
| dg_en_o | output | 1 | Demand downgrades allowed |
| ref_pulse_i | input | 1 | Incoming refresh pulse |
| ref_pulse_o | output | 1 | Refresh pulse forwarded to the array |
| slow_ref_o | output | 1 | Slow refresh active |
| sweep_busy_o | output | 1 | Upgrade walk in progress |
| ln_req_o | output | 1 | Line upgrade request |
| ln_addr_o | output | $clog2(N_RGN)+$clog2(LINES_PER_RGN) | Line address {region, line} |
| ln_ack_i | input | 1 | Line upgrade done |

## Verification
On every cycle the assertions check several rules. The request is held with a stable address until acknowledged. Slow refresh never overlaps a request. Refresh passes straight through whenever it is not slowed. The permit changes only at a window end and is masked outside active mode. A wake in slow refresh takes effect on the next edge. The bench scenarios are needed for the rest: the exact order of visited lines, the clearing and keeping of region marks across repeated idle entries, the 1-in-16 pulse phase and its restart on re-entry, and the strict threshold comparison at its boundaries.

// File: rtl/mecc_pkg.sv
package mecc_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SCAN   = 2'd1,
    ST_LINE   = 2'd2,
    ST_SLOW   = 2'd3
  } mecc_state_e;
endpackage

// File: rtl/mecc_region_map.sv
module mecc_region_map #(
  parameter int N_RGN = 8,
  localparam int RGN_W = $clog2(N_RGN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [RGN_W-1:0] set_idx_i,
  input  logic             clr_i,
  input  logic [RGN_W-1:0] clr_idx_i,
  output logic [N_RGN-1:0] map_o
);
  for (genvar g = 0; g < N_RGN; g++) begin : g_bit
    // set wins over clear: a fresh downgrade must not be lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    map_o[g] <= 1'b0;
      else if (set_i && set_idx_i == RGN_W'(g))       map_o[g] <= 1'b1;
      else if (clr_i && clr_idx_i == RGN_W'(g))       map_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/mecc_ref_div.sv
module mecc_ref_div #(
  parameter int DIV_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  input  logic pulse_i,
  output logic pulse_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!slow_i)    cnt_q <= '0;
    else if (pulse_i)    cnt_q <= cnt_q + 1'b1;
  end

  // forward on counter wrap only while slowed
  assign pulse_o = pulse_i & (~slow_i | (&cnt_q));
endmodule

// File: rtl/mecc_act_gate.sv
module mecc_act_gate #(
  parameter int WINDOW = 1024,
  localparam int MISS_W = $clog2(WINDOW + 1),
  localparam int WIN_W  = $clog2(WINDOW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [MISS_W-1:0] thresh_i,
  output logic              en_o,
  output logic              win_end_o
);
  logic [WIN_W-1:0]  win_q;
  logic [MISS_W-1:0] miss_q;
  logic [MISS_W-1:0] total;

  assign win_end_o = (win_q == WIN_W'(WINDOW - 1));
  assign total     = miss_q + MISS_W'(miss_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      miss_q <= '0;
      en_o   <= 1'b0;
    end else if (win_end_o) begin
      win_q  <= '0;
      miss_q <= '0;
      en_o   <= (total > thresh_i);
    end else begin
      win_q  <= win_q + 1'b1;
      miss_q <= total;
    end
  end
endmodule

// File: rtl/mecc_sweep_fsm.sv
module mecc_sweep_fsm
  import mecc_pkg::*;
#(
  parameter int N_RGN         = 8,
  parameter int LINES_PER_RGN = 2097152,
  localparam int RGN_W  = $clog2(N_RGN),
  localparam int LINE_W = $clog2(LINES_PER_RGN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    idle_i,
  input  logic [N_RGN-1:0]        map_i,
  input  logic                    ack_i,
  output mecc_state_e             state_o,
  output logic                    req_o,
  output logic [RGN_W+LINE_W-1:0] addr_o,
  output logic                    clr_o,
  output logic [RGN_W-1:0]        clr_idx_o
);
  localparam logic [RGN_W-1:0]  LAST_RGN  = RGN_W'(N_RGN - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_RGN - 1);

  mecc_state_e       state_q, state_d;
  logic [RGN_W-1:0]  rgn_q, rgn_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              last_line;

  assign last_line = (line_q == LAST_LINE);

  always_comb begin
    state_d = state_q;
    rgn_d   = rgn_q;
    line_d  = line_q;
    unique case (state_q)
      ST_ACTIVE: if (idle_i) begin
        state_d = ST_SCAN;
        rgn_d   = '0;
      end
      ST_SCAN: begin
        if (!idle_i)             state_d = ST_ACTIVE;
        else if (map_i[rgn_q]) begin
          state_d = ST_LINE;
          line_d  = '0;
        end
        else if (rgn_q == LAST_RGN) state_d = ST_SLOW;
        else                     rgn_d = rgn_q + 1'b1;
      end
      ST_LINE: if (ack_i) begin
        // abort only at a line boundary
        if (!idle_i)                   state_d = ST_ACTIVE;
        else if (!last_line)           line_d  = line_q + 1'b1;
        else if (rgn_q == LAST_RGN)    state_d = ST_SLOW;
        else begin
          state_d = ST_SCAN;
          rgn_d   = rgn_q + 1'b1;
        end
      end
      ST_SLOW: if (!idle_i) state_d = ST_ACTIVE;
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACTIVE;
      rgn_q   <= '0;
      line_q  <= '0;
    end else begin
      state_q <= state_d;
      rgn_q   <= rgn_d;
      line_q  <= line_d;
    end
  end

  assign state_o   = state_q;
  assign req_o     = (state_q == ST_LINE);
  assign addr_o    = {rgn_q, line_q};
  assign clr_o     = (state_q == ST_LINE) && ack_i && last_line;
  assign clr_idx_o = rgn_q;
endmodule

// File: rtl/mecc_mode_ctrl.sv
module mecc_mode_ctrl
  import mecc_pkg::*;
#(
  parameter int N_RGN         = 8,
  parameter int LINES_PER_RGN = 2097152,
  parameter int WINDOW        = 1024,
  parameter int DIV_W         = 4
) (
  input  logic                                             clk_i,
  input  logic                                             rst_ni,
  input  logic                                             idle_i,
  input  logic                                             miss_i,
  input  logic [$clog2(WINDOW+1)-1:0]                      thresh_i,
  input  logic                                             dg_wr_i,
  input  logic [$clog2(N_RGN)-1:0]                         dg_rgn_i,
  output logic                                             dg_en_o,
  input  logic                                             ref_pulse_i,
  output logic                                             ref_pulse_o,
  output logic                                             slow_ref_o,
  output logic                                             sweep_busy_o,
  output logic                                             ln_req_o,
  output logic [$clog2(N_RGN)+$clog2(LINES_PER_RGN)-1:0]   ln_addr_o,
  input  logic                                             ln_ack_i
);
  localparam int RGN_W = $clog2(N_RGN);

  mecc_state_e      state;
  logic [N_RGN-1:0] map;
  logic             clr;
  logic [RGN_W-1:0] clr_idx;
  logic             dg_en_q;
  logic             win_end;

  mecc_region_map #(.N_RGN(N_RGN)) i_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (dg_wr_i),
    .set_idx_i (dg_rgn_i),
    .clr_i     (clr),
    .clr_idx_i (clr_idx),
    .map_o     (map)
  );

  mecc_sweep_fsm #(.N_RGN(N_RGN), .LINES_PER_RGN(LINES_PER_RGN)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_i    (idle_i),
    .map_i     (map),
    .ack_i     (ln_ack_i),
    .state_o   (state),
    .req_o     (ln_req_o),
    .addr_o    (ln_addr_o),
    .clr_o     (clr),
    .clr_idx_o (clr_idx)
  );

  mecc_act_gate #(.WINDOW(WINDOW)) i_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .miss_i    (miss_i),
    .thresh_i  (thresh_i),
    .en_o      (dg_en_q),
    .win_end_o (win_end)
  );

  assign slow_ref_o   = (state == ST_SLOW);
  assign sweep_busy_o = (state == ST_SCAN) || (state == ST_LINE);
  assign dg_en_o      = dg_en_q && (state == ST_ACTIVE);

  mecc_ref_div #(.DIV_W(DIV_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slow_i  (slow_ref_o),
    .pulse_i (ref_pulse_i),
    .pulse_o (ref_pulse_o)
  );
endmodule

// File: rtl/mecc_mode_chk.sv
module mecc_mode_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              idle_i,
  input logic              ln_req_o,
  input logic              ln_ack_i,
  input logic [ADDR_W-1:0] ln_addr_o,
  input logic              slow_ref_o,
  input logic              sweep_busy_o,
  input logic              ref_pulse_i,
  input logic              ref_pulse_o,
  input logic              dg_en_o,
  input logic              dg_en_q,
  input logic              win_end
);
  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ln_req_o && !ln_ack_i |=> ln_req_o && $stable(ln_addr_o));

  a_r6_no_req_when_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_ref_o |-> !ln_req_o);

  a_r6_slow_after_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slow_ref_o) |-> $past(sweep_busy_o));

  a_r8_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slow_ref_o |-> (ref_pulse_o == ref_pulse_i));

  a_r7_slow_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |-> ref_pulse_i);

  a_r9_permit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> $stable(dg_en_q));

  a_r10_dg_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_ref_o || sweep_busy_o) |-> !dg_en_o);

  a_r11_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_ref_o && !idle_i |=> !slow_ref_o);
endmodule

bind mecc_mode_ctrl mecc_mode_chk #(
  .ADDR_W($clog2(N_RGN) + $clog2(LINES_PER_RGN))
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .idle_i       (idle_i),
  .ln_req_o     (ln_req_o),
  .ln_ack_i     (ln_ack_i),
  .ln_addr_o    (ln_addr_o),
  .slow_ref_o   (slow_ref_o),
  .sweep_busy_o (sweep_busy_o),
  .ref_pulse_i  (ref_pulse_i),
  .ref_pulse_o  (ref_pulse_o),
  .dg_en_o      (dg_en_o),
  .dg_en_q      (dg_en_q),
  .win_end      (win_end)
);

// File: tb/test_mecc_mode_ctrl.sv
module test_mecc_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_RGN  = 8;
  localparam int LINES  = 4;
  localparam int WINDOW = 1024;
  localparam int RGN_W  = 3;
  localparam int LINE_W = 2;
  localparam int MISS_W = 11;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic idle_i = 1'b0, miss_i = 1'b0, dg_wr_i = 1'b0, ref_pulse_i = 1'b0, ln_ack_i = 1'b0;
  logic [MISS_W-1:0] thresh_i = '0;
  logic [RGN_W-1:0]  dg_rgn_i = '0;
  logic dg_en_o, ref_pulse_o, slow_ref_o, sweep_busy_o, ln_req_o;
  logic [RGN_W+LINE_W-1:0] ln_addr_o;

  int checks = 0, errors = 0;
  int log_addr [64];
  int log_n = 0;
  int ack_limit = 1000;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mecc_mode_ctrl #(.N_RGN(N_RGN), .LINES_PER_RGN(LINES), .WINDOW(WINDOW)) i_mecc_mode_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle_i), .miss_i(miss_i), .thresh_i(thresh_i),
    .dg_wr_i(dg_wr_i), .dg_rgn_i(dg_rgn_i), .dg_en_o(dg_en_o), .ref_pulse_i(ref_pulse_i),
    .ref_pulse_o(ref_pulse_o), .slow_ref_o(slow_ref_o), .sweep_busy_o(sweep_busy_o),
    .ln_req_o(ln_req_o), .ln_addr_o(ln_addr_o), .ln_ack_i(ln_ack_i));

  // line responder: ack one cycle after request seen, log address
  always @(negedge clk_i) begin
    ln_ack_i <= 1'b0;
    if (ln_req_o && !ln_ack_i && log_n < ack_limit) begin
      if (log_n < 64) log_addr[log_n] = int'(ln_addr_o);
      log_n = log_n + 1;
      ln_ack_i <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; idle_i = 1'b0; miss_i = 1'b0; dg_wr_i = 1'b0; ref_pulse_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic dg_write(input int r);
    @(negedge clk_i); dg_wr_i = 1'b1; dg_rgn_i = RGN_W'(r);
    @(negedge clk_i); dg_wr_i = 1'b0;
  endtask

  task automatic wait_slow(input string tag);
    for (int i = 0; i < 500 && !slow_ref_o; i++) @(negedge clk_i);
    check(slow_ref_o === 1'b1, tag, int'(slow_ref_o), 1);
  endtask

  task automatic ref_burst(input int n, output int outs, output int first);
    outs = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk_i); ref_pulse_i = 1'b1;
      #1;
      if (ref_pulse_o) begin
        outs++;
        if (first == 0) first = i;
      end
      @(negedge clk_i); ref_pulse_i = 1'b0;
    end
  endtask

  task automatic act_case(input int m, input int thr, input bit exp);
    do_reset();
    thresh_i = MISS_W'(thr);
    for (int i = 0; i < WINDOW; i++) begin
      miss_i = (i < m);
      if (i == WINDOW - 1) check(dg_en_o === 1'b0, "R9 permit early", int'(dg_en_o), 0);
      @(negedge clk_i);
    end
    miss_i = 1'b0;
    check(dg_en_o === exp, "R9 permit at window end", int'(dg_en_o), int'(exp));
  endtask

  task automatic check_log(input int r0, input int r1, input string tag);
    check(log_n == 2 * LINES, {tag, " count"}, log_n, 2 * LINES);
    for (int i = 0; i < 2 * LINES && i < log_n; i++) begin
      int e;
      e = ((i < LINES) ? r0 : r1) * LINES + (i % LINES);
      check(log_addr[i] == e, tag, log_addr[i], e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int outs, first;
    do_reset();
    #1;
    check(!slow_ref_o && !ln_req_o && !dg_en_o && !sweep_busy_o, "R1 reset outputs",
          int'({slow_ref_o, ln_req_o, dg_en_o, sweep_busy_o}), 0);

    // R9 threshold boundaries
    act_case(5, 5, 1'b0);
    act_case(6, 5, 1'b1);
    act_case(0, 0, 1'b0);
    act_case(WINDOW, WINDOW - 1, 1'b1);

    // R10: permit masked while walking / slow
    idle_i = 1'b1;
    @(negedge clk_i);
    check(dg_en_o === 1'b0, "R10 masked on idle entry", int'(dg_en_o), 0);
    wait_slow("R6 slow reached, no regions");
    check(dg_en_o === 1'b0, "R10 masked in slow", int'(dg_en_o), 0);
    idle_i = 1'b0;
    @(negedge clk_i);
    check(dg_en_o === 1'b1, "R10 permit back in active", int'(dg_en_o), 1);

    // R2/R3/R7/R8/R11 sweep and refresh
    do_reset();
    ref_burst(5, outs, first);
    check(outs == 5, "R8 full rate passes all", outs, 5);
    dg_write(5); dg_write(1); dg_write(5);
    log_n = 0;
    idle_i = 1'b1;
    wait_slow("R6 slow after sweep");
    check_log(1, 5, "R2 sweep order");
    ref_burst(40, outs, first);
    check(outs == 2, "R7 one in sixteen", outs, 2);
    check(first == 16, "R7 first pass on 16th", first, 16);
    idle_i = 1'b0;
    @(negedge clk_i);
    check(slow_ref_o === 1'b0, "R11 wake", int'(slow_ref_o), 0);
    ref_burst(3, outs, first);
    check(outs == 3, "R8 full rate after wake", outs, 3);
    log_n = 0;
    idle_i = 1'b1;
    wait_slow("R3 slow reached again");
    check(log_n == 0, "R3 cleared regions skipped", log_n, 0);
    ref_burst(10, outs, first);
    check(outs == 0, "R7 no pass before 16", outs, 0);
    idle_i = 1'b0;
    @(negedge clk_i);
    idle_i = 1'b1;
    wait_slow("R7 re-entry slow");
    ref_burst(16, outs, first);
    check(first == 16, "R7 count restart", first, 16);
    idle_i = 1'b0;
    @(negedge clk_i);

    // R5 wake abort at line boundary
    dg_write(1); dg_write(6);
    log_n = 0; ack_limit = 2;
    idle_i = 1'b1;
    for (int i = 0; i < 100 && log_n < 2; i++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    idle_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check(sweep_busy_o && ln_req_o, "R5 outstanding held", int'({sweep_busy_o, ln_req_o}), 3);
    check(int'(ln_addr_o) == LINES + 2, "R4 addr held", int'(ln_addr_o), LINES + 2);
    ack_limit = 1000;
    repeat (4) @(negedge clk_i);
    check(!sweep_busy_o && !slow_ref_o && !ln_req_o, "R5 back to active",
          int'({sweep_busy_o, slow_ref_o, ln_req_o}), 0);
    check(log_n == 3, "R5 stopped after one more line", log_n, 3);
    log_n = 0;
    idle_i = 1'b1;
    wait_slow("R5 slow after resumed sweep");
    check_log(1, 6, "R5 unfinished regions revisited");
    idle_i = 1'b0;
    @(negedge clk_i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule